// File: doc/BRIEF.md
# Operand Hazard and Forwarding Control Unit

This block is the operand-steering control of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) with eight architectural registers named by 3-bit fields. It looks at the instruction now in decode and at the three older instructions still in flight: in execute, in memory and in writeback. It decides, separately for each of the two source operands, where the execute stage should take that operand from one cycle later. The choices are the execute-to-memory result, the memory-to-writeback result, the value that has just been written back, or the register file read.

Selects are chosen in decode and travel with the instruction into execute. An older instruction that is now in execute will therefore sit in the execute/memory latch when the consumer executes. One in memory will sit in the memory/writeback latch, and one in writeback will sit in the write-back holding register. A hit against each stage drives its own select value. The hits are never merged, and the youngest producer wins. A load sitting in execute cannot deliver its data in time for a dependent instruction in decode. For this case the unit holds fetch and decode for one cycle and injects a bubble into execute. On the next cycle the load is in memory and its data is forwarded.

The unit is purely combinational. It also reports the decode instruction's own destination register and write flag, whose position depends on the opcode, so that the pipeline can carry them forward.

Top module: `hz_fwd_unit`

## Requirements
- R1: Instruction fields are: opcode in bits 31:29, source A register in bits 24:22, source B register in bits 18:16, register-type destination in bits 2:0. Opcode codes are add=0, nand=1, load=2, store=3, beq=4, noop=7. Codes 5 and 6 behave as noop.
- R2: `dec_dest`/`dec_writes` give the decode instruction's destination: bits 2:0 for add and nand, the source B field for load. Store, beq and noop write nothing, and for them `dec_dest` is 0.
- R3: An older stage can be a forwarding source only when its valid bit is set, its opcode is add, nand or load, and its destination equals the operand's register. A stage holding store, beq, noop or an invalid slot never matches.
- R4: Select encoding per operand: 3 = execute-stage producer (forward from execute/memory), 2 = memory-stage producer (forward from memory/writeback), 1 = writeback-stage producer (forward from the write-back holding register), 0 = register file.
- R5: When several stages match one operand, the youngest wins: execute over memory over writeback.
- R6: Operand A and operand B are resolved independently and may pick different sources in the same cycle.
- R7: add, nand, store and beq read both A and B. Load reads only A. Noop-class codes read neither. An operand that is not read always selects 0 and never causes a stall.
- R8: `hold_front` and `insert_bubble` are 1 exactly when the execute stage holds a valid load whose destination equals a source that the decode instruction reads.
- R9: A load in the memory or writeback stage never stalls. A dependent instruction forwards from it with select 2 or 1.
- R10: When `dec_valid` is 0, both selects are 0, there is no stall, and `dec_writes` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_valid | input | 1 | Decode slot holds a real instruction |
| dec_instr | input | 32 | Decode instruction word |
| ex_valid | input | 1 | Execute stage valid |
| ex_op | input | 3 | Execute stage opcode |
| ex_dest | input | 3 | Execute stage destination register |
| mem_valid | input | 1 | Memory stage valid |
| mem_op | input | 3 | Memory stage opcode |
| mem_dest | input | 3 | Memory stage destination register |
| wb_valid | input | 1 | Writeback stage valid |
| wb_op | input | 3 | Writeback stage opcode |
| wb_dest | input | 3 | Writeback stage destination register |
| fwd_sel_a | output | 2 | Operand A source select |
| fwd_sel_b | output | 2 | Operand B source select |
| hold_front | output | 1 | Hold PC and fetch/decode latches |
| insert_bubble | output | 1 | Pass a noop into execute |
| dec_dest | output | 3 | Decode instruction destination |
| dec_writes | output | 1 | Decode instruction writes a register |

## Verification
The immediate assertions check on every evaluation that a nonzero select names a stage that really matches and that no younger stage also matches. They also check that unread operands select the register file, that a stall only occurs with a valid load in execute whose select points at it, and that an empty decode slot produces nothing. Only the bench's scenarios show the timing intent: dependences at distances one, two and three map to the right select values, a load-use pair stalls once and then forwards, and two operands fed from different stages resolve together.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int OPW = 3;
  localparam logic [OPW-1:0] OP_ADD  = 3'd0;
  localparam logic [OPW-1:0] OP_NAND = 3'd1;
  localparam logic [OPW-1:0] OP_LW   = 3'd2;
  localparam logic [OPW-1:0] OP_SW   = 3'd3;
  localparam logic [OPW-1:0] OP_BEQ  = 3'd4;
  localparam logic [OPW-1:0] OP_NOOP = 3'd7;

  // Operand source select codes, youngest producer has the highest code
  localparam logic [1:0] SRC_RF  = 2'd0;
  localparam logic [1:0] SRC_WB  = 2'd1;
  localparam logic [1:0] SRC_MEM = 2'd2;
  localparam logic [1:0] SRC_EX  = 2'd3;

  function automatic logic op_writes(input logic [OPW-1:0] op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_LW);
  endfunction

  function automatic logic op_reads_a(input logic [OPW-1:0] op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_LW) ||
           (op == OP_SW)  || (op == OP_BEQ);
  endfunction

  function automatic logic op_reads_b(input logic [OPW-1:0] op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_SW) || (op == OP_BEQ);
  endfunction
endpackage

// File: rtl/hz_field_decode.sv
module hz_field_decode
  import hz_pkg::*;
#(
  parameter int IW     = 32,
  parameter int RW     = 3,
  parameter int OP_LSB = 29,
  parameter int A_LSB  = 22,
  parameter int B_LSB  = 16,
  parameter int D_LSB  = 0
) (
  input  logic          valid,
  input  logic [IW-1:0] instr,
  output logic [OPW-1:0] op,
  output logic [RW-1:0] src_a,
  output logic [RW-1:0] src_b,
  output logic          use_a,
  output logic          use_b,
  output logic [RW-1:0] dest,
  output logic          writes
);
  logic [RW-1:0] rtype_dest;

  always_comb begin
    op         = instr[OP_LSB +: OPW];
    src_a      = instr[A_LSB +: RW];
    src_b      = instr[B_LSB +: RW];
    rtype_dest = instr[D_LSB +: RW];
    use_a      = valid && op_reads_a(op);
    use_b      = valid && op_reads_b(op);
    writes     = valid && op_writes(op);
    // Destination position depends on the opcode: load names it in field B
    if (!writes)          dest = '0;
    else if (op == OP_LW) dest = src_b;
    else                  dest = rtype_dest;
  end

  always_comb begin
    if (writes) assert (op != OP_SW && op != OP_BEQ)
      else $error("AST_NO_WRITE_STORE_BRANCH"); // R2
  end
endmodule

// File: rtl/hz_stage_match.sv
module hz_stage_match
  import hz_pkg::*;
#(
  parameter int RW = 3
) (
  input  logic           stg_valid,
  input  logic [OPW-1:0] stg_op,
  input  logic [RW-1:0]  stg_dest,
  input  logic           src_used,
  input  logic [RW-1:0]  src_reg,
  output logic           hit
);
  always_comb begin
    hit = src_used && stg_valid && op_writes(stg_op) && (stg_dest == src_reg);
  end
endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick #(
  parameter int NSTG = 3,
  localparam int SELW = $clog2(NSTG + 1)
) (
  input  logic [NSTG-1:0] hits,   // index 0 is the youngest stage
  output logic [SELW-1:0] sel
);
  always_comb begin
    sel = '0;
    for (int i = NSTG - 1; i >= 0; i--) begin
      if (hits[i]) sel = SELW'(NSTG - i);
    end
  end

  always_comb begin
    if (sel != '0) begin
      assert (hits[NSTG - int'(sel)])
        else $error("AST_SEL_NAMES_HIT"); // R4
      for (int j = 0; j < NSTG; j++) begin
        if (j < NSTG - int'(sel)) assert (!hits[j])
          else $error("AST_YOUNGEST_WINS"); // R5
      end
    end else begin
      assert (hits == '0) else $error("AST_RF_ONLY_WHEN_NO_HIT"); // R4
    end
  end
endmodule

// File: rtl/hz_load_guard.sv
module hz_load_guard
  import hz_pkg::*;
(
  input  logic           ex_valid,
  input  logic [OPW-1:0] ex_op,
  input  logic           ex_hit_a,
  input  logic           ex_hit_b,
  output logic           stall
);
  always_comb begin
    stall = ex_valid && (ex_op == OP_LW) && (ex_hit_a || ex_hit_b);
  end
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int IW    = 32,
  parameter int NREGS = 8,
  localparam int RW   = $clog2(NREGS),
  localparam int NSTG = 3,
  localparam int NOPS = 2,
  localparam int SELW = $clog2(NSTG + 1)
) (
  input  logic            dec_valid,
  input  logic [IW-1:0]   dec_instr,
  input  logic            ex_valid,
  input  logic [OPW-1:0]  ex_op,
  input  logic [RW-1:0]   ex_dest,
  input  logic            mem_valid,
  input  logic [OPW-1:0]  mem_op,
  input  logic [RW-1:0]   mem_dest,
  input  logic            wb_valid,
  input  logic [OPW-1:0]  wb_op,
  input  logic [RW-1:0]   wb_dest,
  output logic [SELW-1:0] fwd_sel_a,
  output logic [SELW-1:0] fwd_sel_b,
  output logic            hold_front,
  output logic            insert_bubble,
  output logic [RW-1:0]   dec_dest,
  output logic            dec_writes
);
  logic [OPW-1:0] d_op;
  logic [RW-1:0]  d_src [NOPS];
  logic           d_use [NOPS];

  logic           s_valid [NSTG];
  logic [OPW-1:0] s_op    [NSTG];
  logic [RW-1:0]  s_dest  [NSTG];

  logic [NSTG-1:0] hit [NOPS];
  logic [SELW-1:0] sel [NOPS];
  logic            stall;

  hz_field_decode #(.IW(IW), .RW(RW)) u_dec (
    .valid  (dec_valid),
    .instr  (dec_instr),
    .op     (d_op),
    .src_a  (d_src[0]),
    .src_b  (d_src[1]),
    .use_a  (d_use[0]),
    .use_b  (d_use[1]),
    .dest   (dec_dest),
    .writes (dec_writes)
  );

  // Stage order: youngest (execute) first
  always_comb begin
    s_valid[0] = ex_valid;  s_op[0] = ex_op;  s_dest[0] = ex_dest;
    s_valid[1] = mem_valid; s_op[1] = mem_op; s_dest[1] = mem_dest;
    s_valid[2] = wb_valid;  s_op[2] = wb_op;  s_dest[2] = wb_dest;
  end

  for (genvar o = 0; o < NOPS; o++) begin : g_opnd
    for (genvar s = 0; s < NSTG; s++) begin : g_stg
      hz_stage_match #(.RW(RW)) u_match (
        .stg_valid (s_valid[s]),
        .stg_op    (s_op[s]),
        .stg_dest  (s_dest[s]),
        .src_used  (d_use[o]),
        .src_reg   (d_src[o]),
        .hit       (hit[o][s])
      );
    end
    hz_fwd_pick #(.NSTG(NSTG)) u_pick (
      .hits (hit[o]),
      .sel  (sel[o])
    );
  end

  hz_load_guard u_guard (
    .ex_valid (ex_valid),
    .ex_op    (ex_op),
    .ex_hit_a (hit[0][0]),
    .ex_hit_b (hit[1][0]),
    .stall    (stall)
  );

  always_comb begin
    fwd_sel_a     = sel[0];
    fwd_sel_b     = sel[1];
    hold_front    = stall;
    insert_bubble = stall;
  end

  always_comb begin
    if (!d_use[0]) assert (fwd_sel_a == SRC_RF) else $error("AST_UNREAD_A_RF"); // R7
    if (!d_use[1]) assert (fwd_sel_b == SRC_RF) else $error("AST_UNREAD_B_RF"); // R7
    if (hold_front) assert (ex_valid && ex_op == OP_LW)
      else $error("AST_STALL_NEEDS_EX_LOAD"); // R8
    if (hold_front) assert (fwd_sel_a == SRC_EX || fwd_sel_b == SRC_EX)
      else $error("AST_STALL_POINTS_AT_EX"); // R8
    if (!dec_valid) assert (!hold_front && !dec_writes && fwd_sel_a == SRC_RF && fwd_sel_b == SRC_RF)
      else $error("AST_EMPTY_DECODE_QUIET"); // R10
  end
endmodule

// File: tb/sim_hz_fwd_unit.sv
module sim_hz_fwd_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        dec_valid;
  logic [31:0] dec_instr;
  logic        ex_valid, mem_valid, wb_valid;
  logic [2:0]  ex_op, mem_op, wb_op, ex_dest, mem_dest, wb_dest;
  logic [1:0]  fwd_sel_a, fwd_sel_b;
  logic        hold_front, insert_bubble, dec_writes;
  logic [2:0]  dec_dest;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  hz_fwd_unit u0 (.*);

  function automatic logic [31:0] mk(int op, int ra, int rb, int rd);
    logic [31:0] w = 32'h0;
    w[31:29] = 3'(op); w[24:22] = 3'(ra); w[18:16] = 3'(rb); w[2:0] = 3'(rd);
    w[15:3] = 13'h155;  // filler, must be ignored
    return w;
  endfunction

  // Behavioural reference: returns {sel_a, sel_b, hold, bubble, dest, writes}
  function automatic logic [9:0] model();
    int op = int'(dec_instr[31:29]);
    int ra = int'(dec_instr[24:22]);
    int rb = int'(dec_instr[18:16]);
    int rd = int'(dec_instr[2:0]);
    bit ua = dec_valid && (op inside {0, 1, 2, 3, 4});
    bit ub = dec_valid && (op inside {0, 1, 3, 4});
    bit wr = dec_valid && (op inside {0, 1, 2});
    int dd = !wr ? 0 : (op == 2 ? rb : rd);
    int v[3];  int o[3];  int d[3];
    int sa = 0, sb = 0;
    bit st;
    v[0] = ex_valid;  o[0] = ex_op;  d[0] = ex_dest;
    v[1] = mem_valid; o[1] = mem_op; d[1] = mem_dest;
    v[2] = wb_valid;  o[2] = wb_op;  d[2] = wb_dest;
    for (int k = 2; k >= 0; k--) begin
      bit prod = v[k] && (o[k] inside {0, 1, 2});
      if (ua && prod && d[k] == ra) sa = 3 - k;
      if (ub && prod && d[k] == rb) sb = 3 - k;
    end
    st = ex_valid && ex_op == 3'd2 &&
         ((ua && int'(ex_dest) == ra) || (ub && int'(ex_dest) == rb));
    return {2'(sa), 2'(sb), st, st, 3'(dd), wr};
  endfunction

  task automatic set_stg(int idx, bit v, int op, int dst);
    case (idx)
      0: begin ex_valid = v;  ex_op = 3'(op);  ex_dest = 3'(dst);  end
      1: begin mem_valid = v; mem_op = 3'(op); mem_dest = 3'(dst); end
      default: begin wb_valid = v; wb_op = 3'(op); wb_dest = 3'(dst); end
    endcase
  endtask

  task automatic clear();
    dec_valid = 0; dec_instr = '0;
    for (int k = 0; k < 3; k++) set_stg(k, 0, 7, 0);
  endtask

  // Compare against the model and, when given, an explicit expectation
  task automatic check(string tag, logic [9:0] want_explicit, bit use_explicit);
    logic [9:0] got, exp;
    #2;
    got = {fwd_sel_a, fwd_sel_b, hold_front, insert_bubble, dec_dest, dec_writes};
    exp = model();
    n_checks++;
    if (use_explicit && exp !== want_explicit) begin
      n_fail++;
      $display("FAIL %s: model/expectation mismatch exp=%b model=%b", tag, want_explicit, exp);
    end else if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b (selA selB hold bubble dest wr)", tag, got, exp);
    end
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    clear();
    @(negedge clk); check("R10 idle state", {2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0}, 1);

    // R1 R2: field positions and destination by opcode
    @(negedge clk); clear(); dec_valid = 1; dec_instr = mk(0, 5, 6, 4);
    check("R1 R2 add dest from bits 2:0", {2'd0, 2'd0, 1'b0, 1'b0, 3'd4, 1'b1}, 1);
    @(negedge clk); dec_instr = mk(2, 1, 6, 4);
    check("R2 load dest from field B", {2'd0, 2'd0, 1'b0, 1'b0, 3'd6, 1'b1}, 1);
    @(negedge clk); dec_instr = mk(3, 1, 6, 4);
    check("R2 store writes nothing", {2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0}, 1);

    // R4: distances 1, 2, 3
    @(negedge clk); clear(); dec_valid = 1; dec_instr = mk(1, 3, 4, 5);
    set_stg(0, 1, 0, 3);
    check("R4 distance 1 -> ex", {2'd3, 2'd0, 1'b0, 1'b0, 3'd5, 1'b1}, 1);
    @(negedge clk); set_stg(0, 1, 7, 0); set_stg(1, 1, 0, 3);
    check("R4 distance 2 -> mem", {2'd2, 2'd0, 1'b0, 1'b0, 3'd5, 1'b1}, 1);
    @(negedge clk); set_stg(1, 1, 7, 0); set_stg(2, 1, 1, 3);
    check("R4 distance 3 -> wb", {2'd1, 2'd0, 1'b0, 1'b0, 3'd5, 1'b1}, 1);

    // R5: youngest wins
    @(negedge clk); set_stg(0, 1, 0, 3); set_stg(1, 1, 1, 3);
    check("R5 ex beats mem and wb", {2'd3, 2'd0, 1'b0, 1'b0, 3'd5, 1'b1}, 1);

    // R6: operands hit different stages
    @(negedge clk); clear(); dec_valid = 1; dec_instr = mk(0, 2, 6, 1);
    set_stg(1, 1, 0, 2); set_stg(2, 1, 2, 6);
    check("R6 A from mem, B from wb", {2'd2, 2'd1, 1'b0, 1'b0, 3'd1, 1'b1}, 1);

    // R3: non-writers and invalid slots never match
    @(negedge clk); clear(); dec_valid = 1; dec_instr = mk(0, 2, 6, 1);
    set_stg(0, 1, 3, 2); set_stg(1, 1, 4, 6); set_stg(2, 0, 0, 2);
    check("R3 store/beq/invalid ignored", {2'd0, 2'd0, 1'b0, 1'b0, 3'd1, 1'b1}, 1);

    // R8 then R9: load-use stall, then forward
    @(negedge clk); clear(); dec_valid = 1; dec_instr = mk(0, 3, 1, 7);
    set_stg(0, 1, 2, 3);
    check("R8 load-use stall", {2'd3, 2'd0, 1'b1, 1'b1, 3'd7, 1'b1}, 1);
    @(negedge clk); set_stg(0, 1, 7, 0); set_stg(1, 1, 2, 3);
    check("R9 load in mem forwards", {2'd2, 2'd0, 1'b0, 1'b0, 3'd7, 1'b1}, 1);
    @(negedge clk); clear(); dec_valid = 1; dec_instr = mk(3, 0, 3, 0);
    set_stg(0, 1, 2, 3);
    check("R8 store data depends on load", {2'd0, 2'd3, 1'b1, 1'b1, 3'd0, 1'b0}, 1);

    // R7: load does not read B; noop reads nothing
    @(negedge clk); clear(); dec_valid = 1; dec_instr = mk(2, 0, 3, 0);
    set_stg(0, 1, 2, 3);
    check("R7 load B field not a source", {2'd0, 2'd0, 1'b0, 1'b0, 3'd3, 1'b1}, 1);
    @(negedge clk); dec_instr = mk(7, 3, 3, 3);
    check("R7 noop reads nothing", {2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0}, 1);
    @(negedge clk); dec_instr = mk(5, 3, 3, 3);
    check("R1 code 5 behaves as noop", {2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0}, 1);

    // R10: empty decode slot
    @(negedge clk); dec_valid = 0; dec_instr = mk(0, 3, 3, 3);
    check("R10 invalid decode quiet", {2'd0, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0}, 1);

    // Random mix against the model, registers narrowed to provoke hits
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      dec_valid = ($urandom_range(0, 7) != 0);
      dec_instr = $urandom;
      dec_instr[24:22] = 3'($urandom_range(0, 3));
      dec_instr[18:16] = 3'($urandom_range(0, 3));
      for (int k = 0; k < 3; k++)
        set_stg(k, $urandom_range(0, 5) != 0, $urandom_range(0, 7), $urandom_range(0, 3));
      check("R4 R5 R6 R8 random", '0, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule